// File: doc/BRIEF.md
# Home Directory Controller for a Linked-List Shared Line

This block is the home-side directory controller for a single memory line whose sharing caches are chained in a singly linked list. The directory keeps only a line state and one pointer to the head of the list. Each cache holds its own link to the next sharer, so the controller never sees the whole list. The controller also holds the memory copy of the line as a small word array.

Each cycle it may take one incoming coherence message: a read miss, a write miss, a word update bound for memory, a replace request, a replace acknowledgement, or an update that a cache has bounced back. One cycle later it issues at most one outgoing message. That message is a miss reply from memory, a forward to the current head, a flush, a replace completion, or a bounce back to the sender.

On a miss to a shared line, the request goes to the old head and the requester becomes the new head. While the list is being restructured after a replace, the line is held in a replacing state. In that state every request is bounced until the restructure is acknowledged.

Top module: `dir_home_ctl`

## Requirements
- R1: After reset the line state is Absent (code 0), the head pointer is 0, and no message is issued.
- R2: A read miss (op 0) or write miss (op 1) to an Absent line issues a miss reply (op 1) to the requester and sets the head pointer to the requester. The line becomes Present (code 1). A write miss stores its word, and the reply carries that word. A read-miss reply carries the stored word at the requested offset.
- R3: A read miss to a Present line issues a read forward (op 2) to the old head, carrying the requester id. The head pointer becomes the requester.
- R4: A write miss to a Present line issues a write forward (op 3) to the old head, carrying the requester id and the new word. Memory takes the word, and the head pointer becomes the requester.
- R5: A word update (op 2) to a Present line is written to memory. If it comes from a cache other than the head, an update forward (op 4) carrying that word goes to the head. If it comes from the head, no message is issued.
- R6: A replace (op 3) from the head, while that head is still the only holder it has been since the line left Absent, issues a replace completion (op 7) to it. The line returns to Absent.
- R7: A replace from the head of a list with more than one holder issues a flush (op 5) to that head. The line enters Replacing (code 2).
- R8: A replace from a cache other than the head issues a replace forward (op 6) to the head, carrying the replacing cache id. The line enters Replacing.
- R9: While Replacing, every request other than an acknowledgement is bounced. The bounce goes to the sender, uses op 8 plus the original op, and echoes the offset and word. Memory and the head pointer are left unchanged.
- R10: A replace acknowledgement (op 4) while Replacing returns the line to Present and issues no message. If the replace began at the head, the head pointer takes the next-sharer id carried by the acknowledgement. Otherwise the head pointer is unchanged.
- R11: A bounced update (op 5) to a Present line is resent to the head as an update forward carrying memory's current word at that offset.
- R12: Updates, replaces, acknowledgements and bounced updates to an Absent line, and acknowledgements to a Present line, issue no message and change neither state nor head.
- R13: Each accepted request yields at most one message, valid exactly one cycle after the request. A cycle without a request yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming message present this cycle |
| req_op | input | 3 | Incoming message kind |
| req_src | input | IDW | Sending cache id |
| req_off | input | OW | Word offset in the line |
| req_data | input | DW | Word carried by the message |
| req_next | input | IDW | Next-sharer id carried by a replace acknowledgement |
| out_valid | output | 1 | Outgoing message present |
| out_op | output | 4 | Outgoing message kind |
| out_dst | output | IDW | Destination cache id |
| out_req | output | IDW | Originating cache id carried along |
| out_off | output | OW | Word offset |
| out_data | output | DW | Word carried by the outgoing message |
| line_state | output | 2 | Directory line state |
| head_ptr | output | IDW | Directory head pointer |

## Verification
Misses are tried first against an Absent line and then against a Present line. This tells a reply from memory apart from a forward, and shows that the head pointer moves to each new requester. Updates come both from the head and from other sharers, which separates a forwarded update from a silent memory write. Bounced updates then expose the stored words.

Replaces are issued from a sole holder, from a multi-holder head, and from a mid-list sharer. The three produce completion, flush or forward respectively, and the later acknowledgement either adopts the carried next id or keeps the head. While Replacing, every request kind is sent in turn to confirm each is bounced with its own code and leaves memory untouched.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    LS_ABSENT    = 2'd0,
    LS_PRESENT   = 2'd1,
    LS_REPLACING = 2'd2
  } line_t;

  localparam logic [2:0] RQ_RD_MISS = 3'd0;
  localparam logic [2:0] RQ_WR_MISS = 3'd1;
  localparam logic [2:0] RQ_UPDATE  = 3'd2;
  localparam logic [2:0] RQ_REPLACE = 3'd3;
  localparam logic [2:0] RQ_ACK     = 3'd4;
  localparam logic [2:0] RQ_UBOUNCE = 3'd5;

  localparam logic [3:0] MS_REPLY    = 4'd1;
  localparam logic [3:0] MS_RD_FWD   = 4'd2;
  localparam logic [3:0] MS_WR_FWD   = 4'd3;
  localparam logic [3:0] MS_UPD_FWD  = 4'd4;
  localparam logic [3:0] MS_FLUSH    = 4'd5;
  localparam logic [3:0] MS_REPL_FWD = 4'd6;
  localparam logic [3:0] MS_DONE     = 4'd7;
  localparam logic [3:0] MS_BOUNCE   = 4'd8;
endpackage

// File: rtl/dir_mem.sv
module dir_mem #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int OW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [OW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [OW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/dir_state.sv
module dir_state
  import dir_pkg::*;
#(
  parameter int NODES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int OW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [2:0]     req_op,
  input  logic [IDW-1:0] req_src,
  input  logic [OW-1:0]  req_off,
  input  logic [DW-1:0]  req_data,
  input  logic [IDW-1:0] req_next,
  output line_t          state_q,
  output logic [IDW-1:0] head_q,
  output logic           mem_we,
  output logic           msg_valid,
  output logic [3:0]     msg_op,
  output logic [IDW-1:0] msg_dst,
  output logic [IDW-1:0] msg_req,
  output logic [OW-1:0]  msg_off,
  output logic [DW-1:0]  msg_data,
  output logic           msg_from_mem
);
  logic           sole_q, head_repl_q;
  line_t          state_d;
  logic [IDW-1:0] head_d;
  logic           sole_d, head_repl_d;
  logic           emit;
  logic [3:0]     op_d;
  logic [IDW-1:0] dst_d;
  logic           from_mem_d;

  always_comb begin
    state_d     = state_q;
    head_d      = head_q;
    sole_d      = sole_q;
    head_repl_d = head_repl_q;
    emit        = 1'b0;
    op_d        = MS_REPLY;
    dst_d       = head_q;
    from_mem_d  = 1'b0;
    mem_we      = 1'b0;
    if (req_valid) begin
      unique case (state_q)
        LS_ABSENT: begin
          if (req_op == RQ_RD_MISS || req_op == RQ_WR_MISS) begin
            emit       = 1'b1;
            op_d       = MS_REPLY;
            dst_d      = req_src;
            from_mem_d = (req_op == RQ_RD_MISS);
            mem_we     = (req_op == RQ_WR_MISS);
            head_d     = req_src;
            sole_d     = 1'b1;
            state_d    = LS_PRESENT;
          end
        end
        LS_PRESENT: begin
          unique case (req_op)
            RQ_RD_MISS, RQ_WR_MISS: begin
              emit   = 1'b1;
              op_d   = (req_op == RQ_RD_MISS) ? MS_RD_FWD : MS_WR_FWD;
              mem_we = (req_op == RQ_WR_MISS);
              head_d = req_src;
              sole_d = 1'b0;
            end
            RQ_UPDATE: begin
              mem_we = 1'b1;
              emit   = (req_src != head_q);
              op_d   = MS_UPD_FWD;
            end
            RQ_UBOUNCE: begin
              emit       = 1'b1;
              op_d       = MS_UPD_FWD;
              from_mem_d = 1'b1;
            end
            RQ_REPLACE: begin
              emit = 1'b1;
              if (req_src == head_q && sole_q) begin
                op_d    = MS_DONE;
                dst_d   = req_src;
                state_d = LS_ABSENT;
                sole_d  = 1'b0;
              end else if (req_src == head_q) begin
                op_d        = MS_FLUSH;
                dst_d       = req_src;
                state_d     = LS_REPLACING;
                head_repl_d = 1'b1;
              end else begin
                op_d        = MS_REPL_FWD;
                state_d     = LS_REPLACING;
                head_repl_d = 1'b0;
              end
            end
            default: ;
          endcase
        end
        LS_REPLACING: begin
          if (req_op == RQ_ACK) begin
            state_d = LS_PRESENT;
            if (head_repl_q) head_d = req_next;
          end else begin
            emit  = 1'b1;
            op_d  = MS_BOUNCE | {1'b0, req_op};
            dst_d = req_src;
          end
        end
        default: state_d = LS_ABSENT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= LS_ABSENT;
      head_q       <= '0;
      sole_q       <= 1'b0;
      head_repl_q  <= 1'b0;
      msg_valid    <= 1'b0;
      msg_op       <= '0;
      msg_dst      <= '0;
      msg_req      <= '0;
      msg_off      <= '0;
      msg_data     <= '0;
      msg_from_mem <= 1'b0;
    end else begin
      state_q      <= state_d;
      head_q       <= head_d;
      sole_q       <= sole_d;
      head_repl_q  <= head_repl_d;
      msg_valid    <= emit;
      msg_op       <= op_d;
      msg_dst      <= dst_d;
      msg_req      <= req_src;
      msg_off      <= req_off;
      msg_data     <= req_data;
      msg_from_mem <= from_mem_d;
    end
  end
endmodule

// File: rtl/dir_home_ctl.sv
module dir_home_ctl
  import dir_pkg::*;
#(
  parameter int NODES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int OW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [2:0]     req_op,
  input  logic [IDW-1:0] req_src,
  input  logic [OW-1:0]  req_off,
  input  logic [DW-1:0]  req_data,
  input  logic [IDW-1:0] req_next,
  output logic           out_valid,
  output logic [3:0]     out_op,
  output logic [IDW-1:0] out_dst,
  output logic [IDW-1:0] out_req,
  output logic [OW-1:0]  out_off,
  output logic [DW-1:0]  out_data,
  output logic [1:0]     line_state,
  output logic [IDW-1:0] head_ptr
);
  line_t          st;
  logic           mem_we, from_mem;
  logic [DW-1:0]  mem_rdata, msg_data;

  dir_state #(.NODES(NODES), .WORDS(WORDS), .DW(DW)) u_state (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_src(req_src),
    .req_off(req_off), .req_data(req_data), .req_next(req_next),
    .state_q(st), .head_q(head_ptr), .mem_we(mem_we),
    .msg_valid(out_valid), .msg_op(out_op), .msg_dst(out_dst),
    .msg_req(out_req), .msg_off(out_off), .msg_data(msg_data),
    .msg_from_mem(from_mem)
  );

  dir_mem #(.WORDS(WORDS), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(req_off), .wdata(req_data),
    .raddr(req_off), .rdata(mem_rdata)
  );

  assign out_data   = from_mem ? mem_rdata : msg_data;
  assign line_state = st;
endmodule

// File: rtl/dir_home_ctl_chk.sv
module dir_home_ctl_chk #(
  parameter int IDW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [2:0]     req_op,
  input logic [IDW-1:0] req_src,
  input logic           out_valid,
  input logic [3:0]     out_op,
  input logic [IDW-1:0] out_dst,
  input logic [1:0]     line_state,
  input logic [IDW-1:0] head_ptr
);
  AST_ABSENT_REPLY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && line_state == 2'd0 && req_op <= 3'd1)
    |=> (out_valid && out_op == 4'd1 && out_dst == $past(req_src) && line_state == 2'd1)); // R2
  AST_READ_SWAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && line_state == 2'd1 && req_op == 3'd0)
    |=> (out_op == 4'd2 && out_dst == $past(head_ptr) && head_ptr == $past(req_src))); // R3
  AST_REPL_BOUNCE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && line_state == 2'd2 && req_op != 3'd4)
    |=> (out_valid && out_op[3] && out_dst == $past(req_src) && $stable(head_ptr))); // R9
  AST_ACK_RETURN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && line_state == 2'd2 && req_op == 3'd4)
    |=> (line_state == 2'd1 && !out_valid)); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid); // R13
endmodule

bind dir_home_ctl dir_home_ctl_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_src(req_src), .out_valid(out_valid), .out_op(out_op),
  .out_dst(out_dst), .line_state(line_state), .head_ptr(head_ptr)
);

// File: tb/test_dir_home_ctl.sv
module test_dir_home_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int IDW = 3;
  localparam int OW  = 2;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [2:0]     req_op = '0;
  logic [IDW-1:0] req_src = '0;
  logic [OW-1:0]  req_off = '0;
  logic [DW-1:0]  req_data = '0;
  logic [IDW-1:0] req_next = '0;
  logic           out_valid;
  logic [3:0]     out_op;
  logic [IDW-1:0] out_dst, out_req;
  logic [OW-1:0]  out_off;
  logic [DW-1:0]  out_data;
  logic [1:0]     line_state;
  logic [IDW-1:0] head_ptr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home_ctl #(.NODES(8), .WORDS(4), .DW(DW)) i_dir_home_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_src(req_src), .req_off(req_off), .req_data(req_data),
    .req_next(req_next), .out_valid(out_valid), .out_op(out_op),
    .out_dst(out_dst), .out_req(out_req), .out_off(out_off),
    .out_data(out_data), .line_state(line_state), .head_ptr(head_ptr)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, int src, int off, logic [DW-1:0] d, int nxt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src = IDW'(src);
    req_off = OW'(off); req_data = d; req_next = IDW'(nxt);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    chk({req, " idle no message"}, out_valid, 0);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 state", line_state, 0);
    chk("R1 head", head_ptr, 0);
    chk("R1 valid", out_valid, 0);
  endtask

  task automatic t_absent_ignored;
    send(3'd2, 3, 0, 32'h1, 0);
    chk("R12 update absent", out_valid, 0);
    send(3'd4, 3, 0, 32'h0, 5);
    chk("R12 ack absent", out_valid, 0);
    send(3'd3, 3, 0, 32'h0, 0);
    chk("R12 replace absent", out_valid, 0);
    chk("R12 state", line_state, 0);
    chk("R12 head", head_ptr, 0);
  endtask

  task automatic t_absent_write;
    send(3'd1, 2, 1, 32'hA5, 0);
    chk("R2 valid", out_valid, 1);
    chk("R2 op", out_op, 1);
    chk("R2 dst", out_dst, 2);
    chk("R2 data", out_data, 32'hA5);
    chk("R2 state", line_state, 1);
    chk("R2 head", head_ptr, 2);
    idle_check("R13");
  endtask

  task automatic t_present_misses;
    send(3'd0, 5, 1, 32'h0, 0);
    chk("R3 op", out_op, 2);
    chk("R3 dst", out_dst, 2);
    chk("R3 req", out_req, 5);
    chk("R3 head", head_ptr, 5);
    send(3'd1, 6, 2, 32'h77, 0);
    chk("R4 op", out_op, 3);
    chk("R4 dst", out_dst, 5);
    chk("R4 req", out_req, 6);
    chk("R4 data", out_data, 32'h77);
    chk("R4 head", head_ptr, 6);
  endtask

  task automatic t_updates;
    send(3'd2, 2, 1, 32'h99, 0);
    chk("R5 valid", out_valid, 1);
    chk("R5 op", out_op, 4);
    chk("R5 dst", out_dst, 6);
    chk("R5 req", out_req, 2);
    chk("R5 data", out_data, 32'h99);
    send(3'd2, 6, 3, 32'h33, 0);
    chk("R5 head update silent", out_valid, 0);
    send(3'd5, 5, 1, 32'h0, 0);
    chk("R11 op", out_op, 4);
    chk("R11 dst", out_dst, 6);
    chk("R11 data off1", out_data, 32'h99);
    send(3'd5, 5, 2, 32'h0, 0);
    chk("R4 memory took word", out_data, 32'h77);
    send(3'd5, 5, 3, 32'h0, 0);
    chk("R5 head update stored", out_data, 32'h33);
  endtask

  task automatic t_replace_mid;
    send(3'd3, 5, 0, 32'h0, 0);
    chk("R8 op", out_op, 6);
    chk("R8 dst", out_dst, 6);
    chk("R8 req", out_req, 5);
    chk("R8 state", line_state, 2);
    for (int k = 0; k < 6; k++) begin
      if (k == 4) continue;
      send(3'(k), 1, 1, 32'h1234, 0);
      chk("R9 bounce valid", out_valid, 1);
      chk("R9 bounce op", out_op, 8 + k);
      chk("R9 bounce dst", out_dst, 1);
      chk("R9 bounce data", out_data, 32'h1234);
      chk("R9 head kept", head_ptr, 6);
      chk("R9 still replacing", line_state, 2);
    end
    send(3'd4, 5, 0, 32'h0, 3);
    chk("R10 no message", out_valid, 0);
    chk("R10 state", line_state, 1);
    chk("R10 head kept", head_ptr, 6);
    send(3'd5, 5, 1, 32'h0, 0);
    chk("R9 memory untouched", out_data, 32'h99);
  endtask

  task automatic t_replace_head;
    send(3'd3, 6, 0, 32'h0, 0);
    chk("R7 op", out_op, 5);
    chk("R7 dst", out_dst, 6);
    chk("R7 state", line_state, 2);
    send(3'd4, 6, 0, 32'h0, 2);
    chk("R10 state", line_state, 1);
    chk("R10 new head", head_ptr, 2);
    send(3'd4, 2, 0, 32'h0, 4);
    chk("R12 ack present", out_valid, 0);
    chk("R12 head unchanged", head_ptr, 2);
  endtask

  task automatic t_sole;
    do_reset();
    send(3'd1, 4, 0, 32'h5, 0);
    chk("R2 reply", out_op, 1);
    send(3'd3, 4, 0, 32'h0, 0);
    chk("R6 op", out_op, 7);
    chk("R6 dst", out_dst, 4);
    chk("R6 state", line_state, 0);
    send(3'd0, 1, 0, 32'h0, 0);
    chk("R2 read reply op", out_op, 1);
    chk("R2 read reply dst", out_dst, 1);
    chk("R2 read reply data", out_data, 32'h5);
    chk("R2 read head", head_ptr, 1);
  endtask

  initial begin
    t_reset();
    t_absent_ignored();
    t_absent_write();
    t_present_misses();
    t_updates();
    t_replace_mid();
    t_replace_head();
    t_sole();
    idle_check("R13");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule